// File: doc/BRIEF.md
# Sum-of-products output cell with product-term enable

This block models one output cell of a small programmable sum-of-products logic array running in its combinational mode with programmable polarity. A set of signals (the dedicated data inputs and, when the instance allows it, the sensed level of its own pin) is expanded into true and complement literals. Seven product terms are formed over these literals. Each term ANDs the literals whose connection bit is set. Term 0 enables the pin driver. Terms 1 to 6 are ORed into the data sum, and a polarity bit either passes or inverts that sum on its way to the pin.

The configuration word is captured from a parallel port on every clock while reset is applied. It is frozen once reset has been released through a two-stage synchronizer. From the inputs to the pin, the path is purely combinational. The pin is modelled as a data output, an enable output and a separate sensed-level input. An outer instance built with `HAS_FB = 0` has no pin literal, and its sensed-level input is ignored.

Configuration word layout, with `NS` = number of signals and `NL = 2*NS`. Term `t` occupies bits `[t*NL +: NL]`. Within a term, bit `2k` connects signal `k` true and bit `2k+1` connects signal `k` complement. Signals `0..N_IN-1` are `din_i`, and signal `N_IN` is `pad_i` when feedback is present. Above the `7*NL` fuse bits lie the control bits: `+0` polarity, `+1` sync-mode, `+2` arch0 and `+3` arch1.

Top module: `sop_macrocell`

## Requirements
- R1: While `rst_n` is low, and for the first clock edge after it rises, `pad_oe_o` is 0; the cell is ready from the second rising edge after release.
- R2: `cfg_i` is captured on every clock edge until ready (including the edge that makes it ready); later changes to `cfg_i` have no effect on `pad_o` or `pad_oe_o`.
- R3: Product term `t` is the AND of every literal whose bit at `t*NL + 2k` (true) or `t*NL + 2k+1` (complement) is set.
- R4: A term with no bit set is 1; a term that connects both the true and the complement literal of one signal is 0.
- R5: The sum is the OR of terms 1 to 6; when enabled, `pad_o` equals the sum if the polarity bit (`+0`) is 1 and its inverse if it is 0.
- R6: When ready, with sync-mode bit (`+1`) = 1 and arch0 bit (`+2`) = 1, `pad_oe_o` equals term 0.
- R7: If the sync-mode bit or the arch0 bit is 0, `pad_oe_o` is 0.
- R8: The arch1 bit (`+3`) has no effect on either output.
- R9: With `HAS_FB = 1`, `pad_i` is signal `N_IN` of the array; with `HAS_FB = 0`, there is no such signal and `pad_i` has no effect.
- R10: Whenever `pad_oe_o` is 0, `pad_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_i | input | CFG_W | Configuration word captured during reset |
| din_i | input | N_IN | Dedicated data inputs to the array |
| pad_i | input | 1 | Sensed level of the cell's pin |
| pad_o | output | 1 | Pin data when driven |
| pad_oe_o | output | 1 | Pin driver enable (0 = high impedance) |

## Verification
The datapath holds no state, so any wrong configuration bit shows at the pin in the same cycle as the input pattern that depends on it. Random sparse fuse patterns are compared with an independent evaluation of the layout above. A drifting configuration register after release would show as outputs that follow a scrambled `cfg_i`. A wrong release synchronizer would show as the enable rising one cycle early or late around reset release.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int N_CTL = 4;

  // control field above the fuse bits, polarity in the lowest bit
  typedef struct packed {
    logic arch1;
    logic arch0;
    logic sync_mode;
    logic pol_high;
  } ctl_t;
endpackage

// File: rtl/mc_cfg_reg.sv
module mc_cfg_reg #(
  parameter int CFG_W = 102
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             ready_o,
  output logic [CFG_W-1:0] cfg_o
);
  logic [1:0]       rel_q, rel_d;
  logic             load_en;
  logic [CFG_W-1:0] cfg_q;

  always_comb begin
    rel_d   = {rel_q[0], 1'b1};
    load_en = ~rel_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= '0;
    else        rel_q <= rel_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) cfg_q <= cfg_i;
  end

  assign ready_o = rel_q[1];
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/mc_and_array.sv
module mc_and_array #(
  parameter int N_SIG   = 7,
  parameter int N_TERMS = 7,
  localparam int N_LIT  = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]         sig_i,
  input  logic [N_TERMS*N_LIT-1:0] fuse_i,
  output logic [N_TERMS-1:0]       term_o
);
  logic [N_LIT-1:0] lit;

  for (genvar k = 0; k < N_SIG; k++) begin : g_lit
    assign lit[2*k]   = sig_i[k];
    assign lit[2*k+1] = ~sig_i[k];
  end

  // unconnected literals read as 1 so an empty term is true
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    assign term_o[t] = &(lit | ~fuse_i[t*N_LIT +: N_LIT]);
  end
endmodule

// File: rtl/mc_out_stage.sv
module mc_out_stage import mc_pkg::*; #(
  parameter int N_TERMS = 7
) (
  input  logic [N_TERMS-1:0] term_i,
  input  ctl_t               ctl_i,
  input  logic               ready_i,
  output logic               pad_o,
  output logic               pad_oe_o
);
  logic sum, mode_ok, oe, data;

  always_comb begin
    sum     = |term_i[N_TERMS-1:1];
    mode_ok = ctl_i.sync_mode & ctl_i.arch0;
    oe      = ready_i & mode_ok & term_i[0];
    data    = ctl_i.pol_high ? sum : ~sum;
  end

  assign pad_oe_o = oe;
  assign pad_o    = oe & data;
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell import mc_pkg::*; #(
  parameter int  N_IN    = 6,
  parameter int  N_TERMS = 7,
  parameter bit  HAS_FB  = 1'b1,
  localparam int N_SIG   = N_IN + (HAS_FB ? 1 : 0),
  localparam int N_LIT   = 2 * N_SIG,
  localparam int FUSE_W  = N_TERMS * N_LIT,
  localparam int CFG_W   = FUSE_W + N_CTL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [N_IN-1:0]  din_i,
  input  logic             pad_i,
  output logic             pad_o,
  output logic             pad_oe_o
);
  logic               ready;
  logic [CFG_W-1:0]   cfg_q;
  logic [N_SIG-1:0]   sig;
  logic [N_TERMS-1:0] terms;
  ctl_t               ctl;

  mc_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_i   (cfg_i),
    .ready_o (ready),
    .cfg_o   (cfg_q)
  );

  if (HAS_FB) begin : g_fb
    assign sig = {pad_i, din_i};
  end else begin : g_nofb
    assign sig = din_i;
    logic unused_pad;
    assign unused_pad = pad_i;
  end

  mc_and_array #(.N_SIG(N_SIG), .N_TERMS(N_TERMS)) u_arr (
    .sig_i  (sig),
    .fuse_i (cfg_q[FUSE_W-1:0]),
    .term_o (terms)
  );

  assign ctl = ctl_t'(cfg_q[FUSE_W +: N_CTL]);

  mc_out_stage #(.N_TERMS(N_TERMS)) u_out (
    .term_i   (terms),
    .ctl_i    (ctl),
    .ready_i  (ready),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o)
  );
endmodule

// File: rtl/mc_chk.sv
module mc_chk #(
  parameter int N_TERMS = 7,
  parameter int FUSE_W  = 98,
  parameter int CFG_W   = 102
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ready,
  input logic [CFG_W-1:0]   cfg_q,
  input logic [N_TERMS-1:0] terms,
  input logic               pad_o,
  input logic               pad_oe_o
);
  // R1
  oe_in_reset_chk: assert property (@(posedge clk) !rst_n |-> !pad_oe_o);

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready) |-> $stable(cfg_q));

  // R7
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_q[FUSE_W+1] && cfg_q[FUSE_W+2]) |-> !pad_oe_o);

  // R6
  oe_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && cfg_q[FUSE_W+1] && cfg_q[FUSE_W+2]) |-> (pad_oe_o == terms[0]));

  // R5
  polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe_o |-> (pad_o == (cfg_q[FUSE_W] ? |terms[N_TERMS-1:1] : !(|terms[N_TERMS-1:1]))));

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe_o |-> !pad_o);
endmodule

bind sop_macrocell mc_chk #(.N_TERMS(N_TERMS), .FUSE_W(FUSE_W), .CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (ready),
  .cfg_q    (cfg_q),
  .terms    (terms),
  .pad_o    (pad_o),
  .pad_oe_o (pad_oe_o)
);

// File: tb/tb_sop_macrocell.sv
`timescale 1ns/1ps
module tb_sop_macrocell;
  localparam int NI   = 6;
  localparam int W_FB = 7 * 14 + 4;
  localparam int W_ED = 7 * 12 + 4;

  typedef struct {
    logic [1:0] e_fb;
    logic [1:0] e_ed;
    string      tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [W_FB-1:0] cf = '0, mf = '0;
  logic [W_FB-1:0] ce = '0, me = '0;
  logic [NI-1:0]   din = '0;
  logic            pad = 1'b0;
  logic            fb_o, fb_oe, ed_o, ed_oe;
  item_t           q[$];
  int              checks = 0, failures = 0;
  bit              done = 1'b0;

  always #10 clk = ~clk;

  sop_macrocell #(.N_IN(NI), .HAS_FB(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cf), .din_i(din), .pad_i(pad),
    .pad_o(fb_o), .pad_oe_o(fb_oe));

  sop_macrocell #(.N_IN(NI), .HAS_FB(1'b0)) dut_edge (
    .clk(clk), .rst_n(rst_n), .cfg_i(ce[W_ED-1:0]), .din_i(din), .pad_i(pad),
    .pad_o(ed_o), .pad_oe_o(ed_oe));

  // independent evaluation of the documented layout; returns {oe, out}
  function automatic logic [1:0] model(input logic [W_FB-1:0] c, input int ns,
                                       input logic [6:0] s, input bit rdy);
    int nl = 2 * ns;
    logic [6:0] tv;
    logic sum, oe;
    for (int t = 0; t < 7; t++) begin
      tv[t] = 1'b1;
      for (int k = 0; k < ns; k++) begin
        if (c[t*nl + 2*k]   && !s[k]) tv[t] = 1'b0;
        if (c[t*nl + 2*k+1] &&  s[k]) tv[t] = 1'b0;
      end
    end
    sum = |tv[6:1];
    oe  = rdy && c[7*nl+1] && c[7*nl+2] && tv[0];
    return {oe, oe && (c[7*nl] ? sum : !sum)};
  endfunction

  function automatic logic [W_FB-1:0] set_ctl(input logic [W_FB-1:0] c, input int ns,
                                              input bit pol, input bit sy, input bit a0, input bit a1);
    logic [W_FB-1:0] r = c;
    r[7*2*ns]   = pol;
    r[7*2*ns+1] = sy;
    r[7*2*ns+2] = a0;
    r[7*2*ns+3] = a1;
    return r;
  endfunction

  function automatic logic [W_FB-1:0] kill(input logic [W_FB-1:0] c, input int ns, input int t);
    logic [W_FB-1:0] r = c;
    r[t*2*ns]   = 1'b1;
    r[t*2*ns+1] = 1'b1;
    return r;
  endfunction

  task automatic drive(input logic [NI-1:0] d, input logic p, input logic r,
                       input bit rdy, input string tag);
    item_t it;
    @(posedge clk);
    #2;
    din = d; pad = p; rst_n = r;
    it.e_fb = model(mf, 7, {p, d}, rdy);
    it.e_ed = model(me, 6, {1'b0, d}, rdy);
    it.tag  = tag;
    q.push_back(it);
  endtask

  task automatic load(input logic [W_FB-1:0] c_fb, input logic [W_FB-1:0] c_ed);
    cf = c_fb; ce = c_ed; mf = c_fb; me = c_ed;
    drive(din, pad, 1'b0, 1'b0, "R1");
    drive(din, pad, 1'b0, 1'b0, "R1");
    drive(din, pad, 1'b1, 1'b0, "R1");
    drive(din, pad, 1'b1, 1'b0, "R1");
    drive(din, pad, 1'b1, 1'b1, "R1");
  endtask

  always @(negedge clk) begin
    item_t it;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks += 2;
      if ({fb_oe, fb_o} !== it.e_fb) begin
        failures++;
        $display("FAIL %s dut {oe,out} actual=%b expected=%b", it.tag, {fb_oe, fb_o}, it.e_fb);
      end
      if ({ed_oe, ed_o} !== it.e_ed) begin
        failures++;
        $display("FAIL %s dut_edge {oe,out} actual=%b expected=%b", it.tag, {ed_oe, ed_o}, it.e_ed);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W_FB-1:0] c, e;
    // R4 R6: empty terms, enable true, sum true
    c = set_ctl('0, 7, 1'b1, 1'b1, 1'b1, 1'b0);
    e = set_ctl('0, 6, 1'b1, 1'b1, 1'b1, 1'b0);
    load(c, e);
    drive(6'h15, 1'b0, 1'b1, 1'b1, "R4");
    // R5: inverted polarity
    load(set_ctl('0, 7, 1'b0, 1'b1, 1'b1, 1'b0), set_ctl('0, 6, 1'b0, 1'b1, 1'b1, 1'b0));
    drive(6'h2a, 1'b1, 1'b1, 1'b1, "R5");
    // R10 R6: contradictory enable term
    load(kill(c, 7, 0), kill(e, 6, 0));
    drive(6'h3f, 1'b1, 1'b1, 1'b1, "R10");
    // R4 R5: all sum terms contradictory, both polarities
    c = set_ctl('0, 7, 1'b1, 1'b1, 1'b1, 1'b0);
    e = set_ctl('0, 6, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int t = 1; t < 7; t++) begin c = kill(c, 7, t); e = kill(e, 6, t); end
    load(c, e);
    drive(6'h07, 1'b0, 1'b1, 1'b1, "R4");
    drive(6'h38, 1'b1, 1'b1, 1'b1, "R5");
    // R7: mode bits
    load(set_ctl('0, 7, 1'b1, 1'b0, 1'b1, 1'b0), set_ctl('0, 6, 1'b1, 1'b1, 1'b0, 1'b0));
    drive(6'h01, 1'b1, 1'b1, 1'b1, "R7");
    // R8: arch1 set must not change anything
    load(set_ctl('0, 7, 1'b1, 1'b1, 1'b1, 1'b1), set_ctl('0, 6, 1'b0, 1'b1, 1'b1, 1'b1));
    drive(6'h11, 1'b0, 1'b1, 1'b1, "R8");
    // R9: term1 = pad literal on the I/O cell, = din0 on the edge cell
    c = set_ctl('0, 7, 1'b1, 1'b1, 1'b1, 1'b0);
    e = set_ctl('0, 6, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int t = 2; t < 7; t++) begin c = kill(c, 7, t); e = kill(e, 6, t); end
    c[1*14 + 2*6] = 1'b1;
    e[1*12 + 0]   = 1'b1;
    load(c, e);
    drive(6'h00, 1'b0, 1'b1, 1'b1, "R9");
    drive(6'h00, 1'b1, 1'b1, 1'b1, "R9");
    drive(6'h01, 1'b0, 1'b1, 1'b1, "R9");
    drive(6'h01, 1'b1, 1'b1, 1'b1, "R9");
    // R3: term1 = din0 & ~din1 on both cells
    c = set_ctl('0, 7, 1'b1, 1'b1, 1'b1, 1'b0);
    e = set_ctl('0, 6, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int t = 2; t < 7; t++) begin c = kill(c, 7, t); e = kill(e, 6, t); end
    c[14 + 0] = 1'b1; c[14 + 3] = 1'b1;
    e[12 + 0] = 1'b1; e[12 + 3] = 1'b1;
    load(c, e);
    for (int v = 0; v < 4; v++) drive(NI'(v), 1'b0, 1'b1, 1'b1, "R3");
    // R2: scramble the load port after release
    cf = '1; ce = '1;
    for (int v = 0; v < 4; v++) drive(NI'(v), 1'b1, 1'b1, 1'b1, "R2");
    // R3: random sparse fuse maps, random mode bits
    for (int n = 0; n < 40; n++) begin
      for (int b = 0; b < W_FB; b++) begin
        c[b] = ($urandom % 10) == 0;
        e[b] = ($urandom % 10) == 0;
      end
      c = set_ctl(c, 7, 1'($urandom), ($urandom % 4) != 0, ($urandom % 4) != 0, 1'($urandom));
      e = set_ctl(e, 6, 1'($urandom), ($urandom % 4) != 0, ($urandom % 4) != 0, 1'($urandom));
      for (int b = 7*12 + 4; b < W_FB; b++) e[b] = 1'b0;
      load(c, e);
      cf = {W_FB{1'b0}} | W_FB'($urandom);
      for (int v = 0; v < 20; v++) drive(NI'($urandom), 1'($urandom), 1'b1, 1'b1, "R3");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule